// File: doc/BRIEF.md
# Compare-match periodic timer channel

A single 16-bit counting channel for periodic event generation, compare-match output control and input-edge timestamping. Software programs it through a small register window. Eight-bit registers select the count rate, the count-clock edge, the counter-clear source, the per-pin action codes and the interrupt enables. The counter and two general registers, A and B, are accessed as full 16-bit halfwords. An external run level, taken from a start register that several channels share, gates counting.

When a general register is in compare mode, it raises its status flag whenever the counter equals it on a count tick. It can also drive its output pin low or high, or toggle it. When the register is selected as the clear source, the counter returns to zero on that tick, so the period is the register value plus one ticks. In capture mode, the general register instead latches the counter on a chosen edge of its input pin. Wrapping from all-ones to zero sets an overflow flag. A flag clears only when software first reads it as 1 and then writes 0 to it. The interrupt output is the OR of the enabled flags.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, both general registers read 16'hFFFF, the control, mode, I/O control, interrupt-enable and status registers read 0, and the interrupt and both pin outputs are 0.
- R2: Byte registers sit at these offsets and read back what was written: control 0, mode 1, I/O control 2, interrupt enable 4. The status register is at 5. The counter (6), general register A (8) and general register B (10) are 16-bit. A write to the counter takes effect on the next clock edge.
- R3: The counter advances only while run_i is 1. Control bits [2:0] select the divider: 0 gives 1, 1 gives 4, 2 gives 16, 3 gives 64, and codes 4 to 7 give 1. The divider phase restarts whenever run_i is 0. While run_i is 0 and no clear occurs, the counter holds its value.
- R4: Control bits [4:3] select the tick edge for dividers above 1. Code 0 gives one tick at the end of each N-cycle phase, code 1 gives one tick at mid-phase (cycle N/2), and codes 2 and 3 give both. For divide-by-1 the edge select has no effect.
- R5: Control bits [7:5] select the counter-clear source. Code 1 clears on an A event and code 2 clears on a B event. Code 3 clears while sync_clr_i is 1. Any other code gives no clearing. A compare-match clear happens on the tick where the counter equals the register, so the period is N+1 ticks.
- R6: A tick while the counter is 16'hFFFF wraps the counter to 0 and sets status bit 4.
- R7: When a general register is in compare mode, it sets its status flag (bit 0 for A, bit 1 for B) on any tick where the counter equals it.
- R8: The I/O control low nibble drives pin A and the high nibble drives pin B. Codes 1, 2 and 3 set the pin to 0 when written. Codes 5, 6 and 7 set it to 1 when written. On a compare match, codes 1 and 5 clear the pin, 2 and 6 set it, and 3 and 7 toggle it. Code 0 and all other codes leave the pin unchanged.
- R9: I/O codes 8, 9 and 10 make the general register capture the counter on a rising, falling or either edge of its input (cap_a_i or cap_b_i) respectively, and set its flag. An edge of the other polarity is ignored. Capture lags the pin by three clock edges.
- R10: A status flag clears only when software writes 0 to its bit after reading the status register while that flag was 1. Writing 1 leaves the flag unchanged. Any status write disarms every pending clear.
- R11: irq_o is 1 exactly when some flag is 1 and its enable bit is 1. Enable bits 0, 1 and 4 correspond to the status bits of the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clears) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data (low byte for 8-bit registers) |
| bus_rdata | output | 16 | Read data for bus_addr |
| run_i | input | 1 | Channel run bit from the shared start register |
| sync_clr_i | input | 1 | Synchronous clear request from a sibling channel |
| cap_a_i | input | 1 | Capture input A |
| cap_b_i | input | 1 | Capture input B |
| irq_o | output | 1 | Interrupt request |
| cmp_a_o | output | 1 | Compare output A |
| cmp_b_o | output | 1 | Compare output B |

## Verification
The hardest states to reach from the ports are the clearing protocol's corners. A flag must survive a write of 0 that comes without a prior read. It must also survive a write of 1 that follows a read. Finally, a read and a write of 0 must clear it. The bench drives exactly those sequences against a flag set by a compare match. Divider and edge coverage comes from random run lengths under random divider and edge codes, checked against a closed-form tick count. A short run and restart at divide-by-4 shows that the divider phase restarts. Capture polarity is checked by moving the counter between edges with the channel stopped, so every captured value is known exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int OFS_CTRL = 0;
  localparam int OFS_MODE = 1;
  localparam int OFS_IOC  = 2;
  localparam int OFS_IER  = 4;
  localparam int OFS_STAT = 5;
  localparam int OFS_CNT  = 6;
  localparam int OFS_GRA  = 8;
  localparam int OFS_GRB  = 10;

  localparam logic [2:0] CLR_NONE = 3'd0;
  localparam logic [2:0] CLR_GRA  = 3'd1;
  localparam logic [2:0] CLR_GRB  = 3'd2;
  localparam logic [2:0] CLR_SYNC = 3'd3;

  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  localparam logic [1:0] ACT_CLR = 2'd1;
  localparam logic [1:0] ACT_SET = 2'd2;
  localparam logic [1:0] ACT_TGL = 2'd3;

  localparam logic [3:0] IOC_CAP_RISE = 4'd8;
  localparam logic [3:0] IOC_CAP_FALL = 4'd9;
  localparam logic [3:0] IOC_CAP_BOTH = 4'd10;

  // Output-compare code carrying a defined initial level (1..3, 5..7)
  function automatic logic ioc_has_level(input logic [3:0] c);
    return (c[3] == 1'b0) && (c[1:0] != 2'd0);
  endfunction

  function automatic logic ioc_is_capture(input logic [3:0] c);
    return (c == IOC_CAP_RISE) || (c == IOC_CAP_FALL) || (c == IOC_CAP_BOTH);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int MAXDIV = 64,
  localparam int PW = $clog2(MAXDIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [2:0] div_i,
  input  logic [1:0] edge_i,
  output logic       tick_o
);
  import tmr_pkg::*;

  logic [PW-1:0] ph_q, ph_d;
  logic [PW-1:0] last_ph, mid_ph;
  logic          div_one;
  logic          at_end, at_mid, edge_hit;

  always_comb begin
    div_one = 1'b0;
    last_ph = '0;
    case (div_i)
      3'd1:    last_ph = PW'((1 << 2) - 1);
      3'd2:    last_ph = PW'((1 << 4) - 1);
      3'd3:    last_ph = PW'((1 << 6) - 1);
      default: div_one = 1'b1;
    endcase
    mid_ph = last_ph >> 1;
  end

  always_comb begin
    at_end = (ph_q == last_ph);
    at_mid = (ph_q == mid_ph);
    case (edge_i)
      EDGE_RISE: edge_hit = at_end;
      EDGE_FALL: edge_hit = at_mid;
      default:   edge_hit = at_end | at_mid;
    endcase
    tick_o = run_i & (div_one | edge_hit);
  end

  always_comb begin
    if (!run_i || div_one || ph_q >= last_ph) ph_d = '0;
    else                                       ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R3: the phase starts over every time the run bit comes back
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (ph_q == '0));

endmodule

// File: rtl/tmr_pin_unit.sv
module tmr_pin_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   ioc_i,
  input  logic         ioc_wr_i,
  input  logic [3:0]   ioc_new_i,
  input  logic         gr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         cap_in_i,
  output logic [W-1:0] gr_o,
  output logic         pin_o,
  output logic         event_o
);
  import tmr_pkg::*;

  logic [W-1:0] gr_q, gr_d;
  logic         pin_q, pin_d;
  logic         s1_q, s2_q, s3_q;
  logic         rise, fall, cap_mode, cap_hit, match;

  always_comb begin
    rise     = s2_q & ~s3_q;
    fall     = ~s2_q & s3_q;
    cap_mode = ioc_is_capture(ioc_i);
    cap_hit  = ((ioc_i == IOC_CAP_RISE) & rise) |
               ((ioc_i == IOC_CAP_FALL) & fall) |
               ((ioc_i == IOC_CAP_BOTH) & (rise | fall));
    match    = ~cap_mode & tick_i & (cnt_i == gr_q);
    event_o  = match | cap_hit;
  end

  always_comb begin
    if (gr_wr_i)      gr_d = wdata_i;
    else if (cap_hit) gr_d = cnt_i;
    else              gr_d = gr_q;
  end

  always_comb begin
    pin_d = pin_q;
    if (ioc_wr_i) begin
      if (ioc_has_level(ioc_new_i)) pin_d = ioc_new_i[2];
    end else if (match && ioc_has_level(ioc_i)) begin
      case (ioc_i[1:0])
        ACT_CLR: pin_d = 1'b0;
        ACT_SET: pin_d = 1'b1;
        ACT_TGL: pin_d = ~pin_q;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_q  <= '1;
      pin_q <= 1'b0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
    end else begin
      gr_q  <= gr_d;
      pin_q <= pin_d;
      s1_q  <= cap_in_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
    end
  end

  assign gr_o  = gr_q;
  assign pin_o = pin_q;

  // R8: the pin moves only on an I/O control write or a compare match
  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ioc_wr_i && !match) |=> $stable(pin_q));

  // R9: the general register moves only on a bus write or a selected edge
  p_gr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gr_wr_i && !cap_hit) |=> $stable(gr_q));

endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] set_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [2:0] wbits_i,
  input  logic [2:0] en_i,
  output logic [2:0] flags_o,
  output logic       irq_o
);
  logic [2:0] flags_q, flags_d;
  logic [2:0] arm_q, arm_d;
  logic [2:0] clr;

  always_comb begin
    clr     = {3{wr_i}} & ~wbits_i & arm_q;
    flags_d = set_i | (flags_q & ~clr);
    if (wr_i)      arm_d = '0;
    else if (rd_i) arm_d = arm_q | flags_q;
    else           arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= flags_d;
      arm_q   <= arm_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  // R10: a flag can fall only after a read-armed write of 0
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[0]) |-> $past(wr_i && !wbits_i[0] && arm_q[0]));

  // R7: a reported event is visible as a flag one cycle later
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[1] |=> flags_q[1]);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W  = 16,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 4,
  parameter int MAXDIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              run_i,
  input  logic              sync_clr_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  output logic              irq_o,
  output logic              cmp_a_o,
  output logic              cmp_b_o
);
  import tmr_pkg::*;

  localparam int NPIN = 2;

  logic [REG_W-1:0] ctrl_q, mode_q, ioc_q, ier_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ctrl, wr_mode, wr_ioc, wr_ier, wr_stat, wr_cnt, rd_stat;
  logic             tick, clr_hit, ovf_hit;
  logic [2:0]       clr_sel;
  logic [2:0]       flags;
  logic [CNT_W-1:0] gr_w  [NPIN];
  logic             pin_w [NPIN];
  logic             evt_w [NPIN];
  logic             cap_w [NPIN];

  assign cap_w[0] = cap_a_i;
  assign cap_w[1] = cap_b_i;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_mode = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
    wr_ioc  = bus_wr && (bus_addr == ADDR_W'(OFS_IOC));
    wr_ier  = bus_wr && (bus_addr == ADDR_W'(OFS_IER));
    wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    wr_cnt  = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
    rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      ier_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[REG_W-1:0];
      if (wr_mode) mode_q <= bus_wdata[REG_W-1:0];
      if (wr_ioc)  ioc_q  <= bus_wdata[REG_W-1:0];
      if (wr_ier)  ier_q  <= bus_wdata[REG_W-1:0];
    end
  end

  tmr_prescaler #(.MAXDIV(MAXDIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .div_i  (ctrl_q[2:0]),
    .edge_i (ctrl_q[4:3]),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    tmr_pin_unit #(.W(CNT_W)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .ioc_i     (ioc_q[4*i +: 4]),
      .ioc_wr_i  (wr_ioc),
      .ioc_new_i (bus_wdata[4*i +: 4]),
      .gr_wr_i   (bus_wr && (bus_addr == ADDR_W'(OFS_GRA + 2*i))),
      .wdata_i   (bus_wdata),
      .cnt_i     (cnt_q),
      .tick_i    (tick),
      .cap_in_i  (cap_w[i]),
      .gr_o      (gr_w[i]),
      .pin_o     (pin_w[i]),
      .event_o   (evt_w[i])
    );
  end

  always_comb begin
    clr_sel = ctrl_q[7:5];
    case (clr_sel)
      CLR_GRA:  clr_hit = evt_w[0];
      CLR_GRB:  clr_hit = evt_w[1];
      CLR_SYNC: clr_hit = sync_clr_i;
      default:  clr_hit = 1'b0;
    endcase
    ovf_hit = tick & (&cnt_q);
    if (wr_cnt)       cnt_d = bus_wdata;
    else if (clr_hit) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  tmr_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   ({ovf_hit, evt_w[1], evt_w[0]}),
    .rd_i    (rd_stat),
    .wr_i    (wr_stat),
    .wbits_i ({bus_wdata[4], bus_wdata[1], bus_wdata[0]}),
    .en_i    ({ier_q[4], ier_q[1], ier_q[0]}),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): bus_rdata[REG_W-1:0] = ctrl_q;
      ADDR_W'(OFS_MODE): bus_rdata[REG_W-1:0] = mode_q;
      ADDR_W'(OFS_IOC):  bus_rdata[REG_W-1:0] = ioc_q;
      ADDR_W'(OFS_IER):  bus_rdata[REG_W-1:0] = ier_q;
      ADDR_W'(OFS_STAT): bus_rdata[4:0] = {flags[2], 2'b00, flags[1], flags[0]};
      ADDR_W'(OFS_CNT):  bus_rdata = cnt_q;
      ADDR_W'(OFS_GRA):  bus_rdata = gr_w[0];
      ADDR_W'(OFS_GRB):  bus_rdata = gr_w[1];
      default:           bus_rdata = '0;
    endcase
  end

  assign cmp_a_o = pin_w[0];
  assign cmp_b_o = pin_w[1];

  // R3: a stopped channel keeps its count unless written or cleared
  p_count_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_cnt && !clr_hit) |=> $stable(cnt_q));

  // R5: a compare match on the chosen clear register returns the count to 0
  p_period_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == CLR_GRA && evt_w[0] && !wr_cnt) |=> (cnt_q == '0));

  // R6: a tick at all-ones raises the overflow flag
  p_overflow_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q)) |=> flags[2]);

endmodule

// File: tb/tmr_channel_tb.sv
`timescale 1ns/1ps
module tmr_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        run_i = 1'b0, sync_clr_i = 1'b0, cap_a_i = 1'b0, cap_b_i = 1'b0;
  logic        irq_o, cmp_a_o, cmp_b_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run_i(run_i), .sync_clr_i(sync_clr_i), .cap_a_i(cap_a_i), .cap_b_i(cap_b_i),
    .irq_o(irq_o), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic run_for(input int k);
    @(negedge clk); run_i = 1'b1;
    repeat (k) @(negedge clk);
    run_i = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Expected tick count for k running cycles (R3, R4)
  function automatic int exp_ticks(input int k, input int div, input int edg);
    int n;
    n = (div == 1) ? 4 : (div == 2) ? 16 : (div == 3) ? 64 : 1;
    if (n == 1) return k;
    if (edg == 0) return k / n;
    if (edg == 1) return (k + n / 2) / n;
    return k / n + (k + n / 2) / n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, rv); check("R1 ctrl", rv, 16'h0000);
    rd(4'd6, rv); check("R1 counter", rv, 16'h0000);
    rd(4'd8, rv); check("R1 gra", rv, 16'hFFFF);
    rd(4'd10, rv); check("R1 grb", rv, 16'hFFFF);
    rd(4'd5, rv); check("R1 status", rv, 16'h0000);
    check("R1 irq", irq_o, 1'b0);
    check("R1 pins", {cmp_b_o, cmp_a_o}, 2'b00);

    // R2 register readback
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      logic [15:0] h;
      b = 8'($urandom);
      wr(4'd1, {8'h00, b}); rd(4'd1, rv); check("R2 mode", rv, {8'h00, b});
      b = 8'($urandom);
      wr(4'd4, {8'h00, b}); rd(4'd4, rv); check("R2 ier", rv, {8'h00, b});
      b = 8'($urandom);
      wr(4'd0, {8'h00, b}); rd(4'd0, rv); check("R2 ctrl", rv, {8'h00, b});
      h = 16'($urandom);
      wr(4'd6, h); rd(4'd6, rv); check("R2 counter", rv, h);
      h = 16'($urandom);
      wr(4'd10, h); rd(4'd10, rv); check("R2 grb", rv, h);
    end
    wr(4'd4, 16'h0000);
    wr(4'd10, 16'hFFFF);
    wr(4'd8, 16'hFFFF);

    // R3 R4 random divider / edge / run length
    for (int i = 0; i < 12; i++) begin
      int div, edg, k;
      div = int'($urandom_range(0, 5));
      edg = int'($urandom_range(0, 2));
      k   = int'($urandom_range(1, 260));
      wr(4'd0, 16'(edg * 8 + div));
      wr(4'd6, 16'h0000);
      run_for(k);
      rd(4'd6, rv);
      check($sformatf("R4 div%0d edge%0d k%0d", div, edg, k), rv, 16'(exp_ticks(k, div, edg)));
    end

    // R3 hold while stopped
    wr(4'd0, 16'h0000); wr(4'd6, 16'h0000);
    run_for(37); idle(9);
    rd(4'd6, rv); check("R3 hold when stopped", rv, 16'd37);

    // R3 divider phase restarts when run drops (div 4, rising)
    wr(4'd0, 16'h0001); wr(4'd6, 16'h0000);
    run_for(3); run_for(3);
    rd(4'd6, rv); check("R3 phase restart", rv, 16'd0);

    // R5 R7 periodic clear on A, period 10
    wr(4'd0, 16'h0020); wr(4'd8, 16'd9); wr(4'd6, 16'h0000);
    run_for(25);
    rd(4'd6, rv); check("R5 clear on A", rv, 16'd5);
    rd(4'd5, rv); check("R7 flag A", rv & 16'h0013, 16'h0001);

    // R11 interrupt enables
    wr(4'd4, 16'h0002); check("R11 irq masked", irq_o, 1'b0);
    wr(4'd4, 16'h0001); check("R11 irq enabled", irq_o, 1'b1);
    wr(4'd4, 16'h0000); check("R11 irq off", irq_o, 1'b0);

    // R10 clearing protocol
    rd(4'd5, rv);
    wr(4'd5, 16'h00FF);
    rd(4'd5, rv); check("R10 write one keeps flag", rv & 16'h0001, 16'h0001);
    wr(4'd5, 16'h00FF);
    wr(4'd5, 16'h0000);
    rd(4'd5, rv); check("R10 unarmed zero keeps flag", rv & 16'h0001, 16'h0001);
    wr(4'd5, 16'h0000);
    rd(4'd5, rv); check("R10 armed zero clears flag", rv & 16'h0001, 16'h0000);

    // R5 R7 clear on B, period 7
    wr(4'd0, 16'h0040); wr(4'd10, 16'd6); wr(4'd6, 16'h0000);
    run_for(16);
    rd(4'd6, rv); check("R5 clear on B", rv, 16'd2);
    rd(4'd5, rv); check("R7 flag B", rv & 16'h0002, 16'h0002);

    // R6 overflow
    wr(4'd0, 16'h0000); wr(4'd6, 16'hFFFE);
    rd(4'd5, rv); check("R6 no overflow yet", rv & 16'h0010, 16'h0000);
    run_for(3);
    rd(4'd6, rv); check("R6 wrap", rv, 16'd1);
    rd(4'd5, rv); check("R6 overflow flag", rv & 16'h0010, 16'h0010);
    wr(4'd4, 16'h0010); check("R11 overflow irq", irq_o, 1'b1);
    wr(4'd4, 16'h0000);

    // R5 synchronous clear
    wr(4'd0, 16'h0060); wr(4'd6, 16'h1234);
    @(negedge clk); sync_clr_i = 1'b1; @(negedge clk); sync_clr_i = 1'b0;
    rd(4'd6, rv); check("R5 sync clear", rv, 16'h0000);
    wr(4'd0, 16'h0000); wr(4'd6, 16'h0055);
    @(negedge clk); sync_clr_i = 1'b1; @(negedge clk); sync_clr_i = 1'b0;
    rd(4'd6, rv); check("R5 sync ignored", rv, 16'h0055);

    // R8 output compare actions
    wr(4'd0, 16'h0020); wr(4'd8, 16'd9); wr(4'd10, 16'd4); wr(4'd6, 16'h0000);
    wr(4'd2, 16'h0053);
    check("R8 initial levels", {cmp_b_o, cmp_a_o}, 2'b10);
    run_for(10);
    check("R8 toggle A clear B", {cmp_b_o, cmp_a_o}, 2'b01);
    run_for(10);
    check("R8 toggle back", {cmp_b_o, cmp_a_o}, 2'b00);
    wr(4'd2, 16'h0067);
    check("R8 initial high", {cmp_b_o, cmp_a_o}, 2'b11);
    run_for(10);
    check("R8 set B toggle A", {cmp_b_o, cmp_a_o}, 2'b10);
    wr(4'd2, 16'h0000);
    run_for(10);
    check("R8 retain code", {cmp_b_o, cmp_a_o}, 2'b10);

    // R9 input capture
    wr(4'd0, 16'h0000);
    rd(4'd5, rv); wr(4'd5, 16'h0000);
    wr(4'd2, 16'h0008); wr(4'd6, 16'h0ABC);
    @(negedge clk); cap_a_i = 1'b1; idle(4);
    rd(4'd8, rv); check("R9 rising capture", rv, 16'h0ABC);
    rd(4'd5, rv); check("R9 capture flag", rv & 16'h0001, 16'h0001);
    wr(4'd6, 16'h0111);
    @(negedge clk); cap_a_i = 1'b0; idle(4);
    rd(4'd8, rv); check("R9 falling ignored", rv, 16'h0ABC);
    wr(4'd2, 16'h0009); wr(4'd6, 16'h0222);
    @(negedge clk); cap_a_i = 1'b1; idle(4);
    rd(4'd8, rv); check("R9 rising ignored", rv, 16'h0ABC);
    wr(4'd6, 16'h0333);
    @(negedge clk); cap_a_i = 1'b0; idle(4);
    rd(4'd8, rv); check("R9 falling capture", rv, 16'h0333);
    wr(4'd2, 16'h00A0); wr(4'd6, 16'h0444);
    @(negedge clk); cap_b_i = 1'b1; idle(4);
    rd(4'd10, rv); check("R9 both rise", rv, 16'h0444);
    wr(4'd6, 16'h0555);
    @(negedge clk); cap_b_i = 1'b0; idle(4);
    rd(4'd10, rv); check("R9 both fall", rv, 16'h0555);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule